// File: doc/BRIEF.md
# Event-to-clock interval gate

This block opens a measurement gate the instant an asynchronous event pulse arrives and closes it on a later edge of the local timing clock. The opening is not clocked at all: the event acts as an asynchronous set on the gate flop. A second, clocked stage copies the gate on the first rising edge after the event. The gate is cleared on the edge after that. Because of this, every gate is longer than one clock period and no longer than two. That spread gives the downstream charge or stretch stage a bounded interval to convert and time to recover. With a 1 GHz timing clock, the longest gate is 2 ns.

Each closed gate raises a one-cycle done flag for the control logic. A static mode input selects the conversion variant. In that variant, closing the gate raises a conversion request that stays up until a done input comes back. A baseline-reset output then drives the capacitor stage back to its rest level for a fixed number of cycles. From the event until the block is re-armed, a busy output is high and further events are ignored. The analog stage, the discriminators, the PLL and the converter are outside the block. The bench stands in for them through the handshake pins.

Top module: `evt_interval_gate`

## Requirements
- R1: While `rst_ni` is low, `gate_o`, `busy_o`, `evt_flag_o`, `conv_req_o` and `base_rst_o` are all 0.
- R2: When the block is armed, a rising `ev_i` drives `gate_o` to 1 at once, with no clock edge involved.
- R3: `gate_o` falls on the second rising clock edge after the event that opened it. Its high time is therefore more than one clock period and at most two.
- R4: `busy_o` is 1 from the event until the block is re-armed, and it is 1 whenever `gate_o` is 1.
- R5: `evt_flag_o` is high for exactly one clock cycle, starting at the edge that closes the gate.
- R6: With `conv_mode_i` = 0, the block is re-armed at the edge that closes the gate. An event after that edge opens a new gate.
- R7: With `conv_mode_i` = 1, `conv_req_o` rises at the edge that closes the gate. It stays high until the edge at which `conv_done_i` is sampled high.
- R8: At that edge, `base_rst_o` rises. It stays high for exactly `BASE_CYC` cycles (4 by default), and the block is re-armed as it falls. `conv_req_o` and `base_rst_o` are never high together.
- R9: An event arriving while `busy_o` is 1 changes neither the gate nor the flag sequence.
- R10: `conv_done_i` has no effect unless `conv_req_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local timing clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ev_i | input | 1 | Asynchronous event pulse, shorter than one clock period |
| conv_mode_i | input | 1 | 1 selects the conversion/baseline handshake; change only while idle |
| conv_done_i | input | 1 | Conversion finished, sampled on the clock |
| gate_o | output | 1 | Measured interval |
| busy_o | output | 1 | Measurement or baseline reset in progress |
| evt_flag_o | output | 1 | One-cycle pulse when a gate has closed |
| conv_req_o | output | 1 | Conversion request (conversion mode) |
| base_rst_o | output | 1 | Baseline reset of the capacitor stage (conversion mode) |

## Verification
`gate_o` is due at once after the event and is sampled half a nanosecond later. Its falling edge is timed against the rising edge to land within one to two periods.

The clocked results fall due at fixed edges after the event:
- the done flag and the conversion request at the second edge;
- the baseline reset at the edge that samples the done input;
- re-arming `BASE_CYC` edges after that.

A behavioural model advances at each rising edge and is compared with the outputs at the falling edge, so every value is read mid-cycle. Events are placed at random phases that stay clear of both clock edges.

// File: rtl/evg_pkg.sv
package evg_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HOLD = 2'd1,
        ST_CONV = 2'd2,
        ST_BASE = 2'd3
    } evg_state_e;
endpackage

// File: rtl/evg_gate_latch.sv
// Gate flop: set asynchronously by an armed event, cleared on the clock.
module evg_gate_latch (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic ev_i,
    input  logic arm_i,
    input  logic clr_i,
    output logic gate_o
);
    logic set_w;
    logic gate_q;

    assign set_w = ev_i & arm_i;

    always_ff @(posedge clk_i or negedge rst_ni or posedge set_w) begin
        if (!rst_ni) begin
            gate_q <= 1'b0;
        end else if (set_w) begin
            gate_q <= 1'b1;
        end else if (clr_i) begin
            gate_q <= 1'b0;
        end
    end

    assign gate_o = gate_q;
endmodule

// File: rtl/evg_ctrl.sv
// Clocked sequencer: second stage, conversion wait, baseline hold.
module evg_ctrl #(
    parameter int unsigned BASE_CYC = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic gate_i,
    input  logic conv_mode_i,
    input  logic conv_done_i,
    output logic arm_o,
    output logic stage_o,
    output logic close_o,
    output logic conv_req_o,
    output logic base_rst_o
);
    import evg_pkg::*;

    localparam int unsigned CNT_W = $clog2(BASE_CYC + 1);

    typedef struct packed {
        evg_state_e       st;
        logic             stage;
        logic [CNT_W-1:0] left;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (gate_i) begin
                    ctl_d.st    = ST_HOLD;
                    ctl_d.stage = 1'b1;
                end
            end
            ST_HOLD: begin
                ctl_d.stage = 1'b0;
                ctl_d.st    = conv_mode_i ? ST_CONV : ST_IDLE;
            end
            ST_CONV: begin
                if (conv_done_i) begin
                    ctl_d.st   = ST_BASE;
                    ctl_d.left = CNT_W'(BASE_CYC);
                end
            end
            ST_BASE: begin
                if (ctl_q.left == CNT_W'(1)) begin
                    ctl_d.st   = ST_IDLE;
                    ctl_d.left = '0;
                end else begin
                    ctl_d.left = ctl_q.left - CNT_W'(1);
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctl_q <= '{st: ST_IDLE, stage: 1'b0, left: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign arm_o      = (ctl_q.st == ST_IDLE);
    assign stage_o    = ctl_q.stage;
    assign close_o    = (ctl_q.st == ST_HOLD);
    assign conv_req_o = (ctl_q.st == ST_CONV);
    assign base_rst_o = (ctl_q.st == ST_BASE);
endmodule

// File: rtl/evg_flag.sv
// One-cycle done flag registered on the closing edge.
module evg_flag (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic close_i,
    output logic flag_o
);
    typedef struct packed {
        logic flag;
    } flag_t;

    flag_t flg_d, flg_q;

    always_comb begin
        flg_d      = flg_q;
        flg_d.flag = close_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            flg_q <= '{flag: 1'b0};
        end else begin
            flg_q <= flg_d;
        end
    end

    assign flag_o = flg_q.flag;
endmodule

// File: rtl/evt_interval_gate.sv
module evt_interval_gate #(
    parameter int unsigned BASE_CYC = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic ev_i,
    input  logic conv_mode_i,
    input  logic conv_done_i,
    output logic gate_o,
    output logic busy_o,
    output logic evt_flag_o,
    output logic conv_req_o,
    output logic base_rst_o
);
    logic arm_w;
    logic stage_w;
    logic close_w;
    logic gate_w;

    evg_gate_latch u_gate (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .ev_i   (ev_i),
        .arm_i  (arm_w),
        .clr_i  (stage_w),
        .gate_o (gate_w)
    );

    evg_ctrl #(.BASE_CYC(BASE_CYC)) u_ctrl (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .gate_i      (gate_w),
        .conv_mode_i (conv_mode_i),
        .conv_done_i (conv_done_i),
        .arm_o       (arm_w),
        .stage_o     (stage_w),
        .close_o     (close_w),
        .conv_req_o  (conv_req_o),
        .base_rst_o  (base_rst_o)
    );

    evg_flag u_flag (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .close_i (close_w),
        .flag_o  (evt_flag_o)
    );

    assign gate_o = gate_w;
    assign busy_o = gate_w | ~arm_w;
endmodule

// File: rtl/evg_checker.sv
module evg_checker (
    input logic clk_i,
    input logic rst_ni,
    input logic gate_i,
    input logic busy_i,
    input logic flag_i,
    input logic req_i,
    input logic base_i,
    input logic done_i,
    input logic stage_i
);
    assert_flag_one_cycle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flag_i |=> !flag_i);

    assert_flag_follows_stage_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flag_i |-> $past(stage_i));

    assert_stage_one_cycle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stage_i |=> !stage_i);

    assert_busy_covers_gate_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        gate_i |-> busy_i);

    assert_req_holds_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i && !done_i) |=> req_i);

    assert_base_after_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i && done_i) |=> (base_i && !req_i));

    assert_req_base_apart_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(req_i && base_i));

    assert_done_idle_no_base_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!req_i && !base_i) |=> !base_i);
endmodule

bind evt_interval_gate evg_checker u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .gate_i  (gate_o),
    .busy_i  (busy_o),
    .flag_i  (evt_flag_o),
    .req_i   (conv_req_o),
    .base_i  (base_rst_o),
    .done_i  (conv_done_i),
    .stage_i (stage_w)
);

// File: tb/evt_interval_gate_test.sv
`timescale 1ns/1ps
module evt_interval_gate_test;
    localparam int  BASE = 4;
    localparam real TCK  = 20.0;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ev = 1'b0;
    logic mode = 1'b0;
    logic done = 1'b0;
    logic gate, busy, flag, req, base;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // behavioural reference state
    bit m_gate = 0;
    int m_phase = 0; // 0 armed, 1 second stage, 2 awaiting conversion, 3 baseline
    int m_left = 0;
    bit m_flag = 0;

    real t_rise = 0.0;
    bit  rise_seen = 0;

    always #(TCK / 2.0) clk = ~clk;

    evt_interval_gate #(.BASE_CYC(BASE)) uut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .ev_i        (ev),
        .conv_mode_i (mode),
        .conv_done_i (done),
        .gate_o      (gate),
        .busy_o      (busy),
        .evt_flag_o  (flag),
        .conv_req_o  (req),
        .base_rst_o  (base)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_gate = 0; m_phase = 0; m_left = 0; m_flag = 0;
        end else begin
            m_flag = 0;
            case (m_phase)
                0: if (m_gate) m_phase = 1;
                1: begin
                    m_gate = 0; m_flag = 1;
                    m_phase = mode ? 2 : 0;
                end
                2: if (done) begin m_phase = 3; m_left = BASE; end
                3: if (m_left == 1) m_phase = 0; else m_left--;
                default: m_phase = 0;
            endcase
        end
    end

    always @(negedge clk) begin
        if (!rst_n) begin
            chk("R1 gate", gate, 1'b0);
            chk("R1 busy", busy, 1'b0);
            chk("R1 flag", flag, 1'b0);
            chk("R1 req", req, 1'b0);
            chk("R1 base", base, 1'b0);
        end else begin
            chk("R3 gate", gate, m_gate);
            chk("R4 busy", busy, m_gate || m_phase != 0);
            chk("R5 flag", flag, m_flag);
            chk("R7 req", req, m_phase == 2);
            chk("R8 base", base, m_phase == 3);
        end
    end

    always @(posedge gate) begin
        t_rise = $realtime;
        rise_seen = 1;
    end

    always @(negedge gate) begin
        if (rst_n && rise_seen) begin
            real w;
            w = $realtime - t_rise;
            n_chk++;
            if (!(w > TCK && w <= 2.0 * TCK)) begin
                n_fail++;
                $display("FAIL R3 width: got %0.3f ns expected (%0.1f, %0.1f]", w, TCK, 2.0 * TCK);
            end
            rise_seen = 0;
        end
    end

    // event at a random phase after the next rising edge, clear of both edges
    task automatic fire(input string tag);
        int r;
        int off;
        bit armed;
        r = $urandom_range(0, 13);
        off = (r < 8) ? r + 1 : r + 4;
        @(posedge clk);
        #(off);
        armed = (m_phase == 0);
        ev = 1'b1;
        if (armed) m_gate = 1;
        #0.5;
        chk(tag, gate, m_gate);
        #1.5;
        ev = 1'b0;
    endtask

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
    endtask

    initial begin
        idle_cycles(3);
        @(negedge clk) rst_n = 1'b1;
        idle_cycles(2);

        // R2 R3 R5 R6: plain mode, random event phases
        for (int i = 0; i < 30; i++) begin
            fire("R2 gate opens");
            idle_cycles($urandom_range(2, 4));
        end

        // R9: second event inside the busy window; R6: event right after close
        for (int i = 0; i < 8; i++) begin
            fire("R2 gate opens");
            fire("R9 ignored while busy");
            fire("R6 rearmed after close");
            idle_cycles(3);
        end

        // conversion mode: R7 R8 R9 R10
        @(negedge clk) mode = 1'b1;
        for (int i = 0; i < 10; i++) begin
            fire("R2 gate opens");
            idle_cycles(2);
            fire("R9 ignored during conversion");
            idle_cycles(i % 4);
            @(negedge clk) done = 1'b1;
            @(negedge clk) done = (i % 3 == 0);
            idle_cycles(2);
            fire("R9 ignored during baseline");
            @(negedge clk) done = 1'b0;
            idle_cycles(BASE + 2);
            // R10: done while idle must not start a baseline
            @(negedge clk) done = 1'b1;
            @(negedge clk) done = 1'b0;
            chk("R10 base", base, 1'b0);
            idle_cycles(2);
        end

        @(negedge clk) mode = 1'b0;
        for (int i = 0; i < 10; i++) begin
            fire("R6 rearmed plain mode");
            idle_cycles(2);
        end
        idle_cycles(4);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(TCK * 200000.0);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got hang expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule